// File: doc/BRIEF.md
# Wake-up Alarm Control FSM

This block is a three-state synchronous controller that models how a sleeper responds to a ringing alarm. The states are asleep, lying awake in bed, and up. Two single-bit inputs drive it. `alarm_i` says whether the alarm is sounding. `weekday_i` says whether the current day is a working day. One output, `off_req_o`, asks for the alarm to be silenced. The current state code appears on `state_o` so that the surrounding logic or a checker can watch it.

A ringing alarm wakes the sleeper. While the alarm keeps ringing, the sleeper stays in bed. When the alarm stops, the next state depends on the day: on a working day the sleeper gets up, and on any other day the sleeper goes back to sleep. Once up, the machine never leaves that state except through reset.

The elaboration parameter `MEALY` selects how the output is formed. With `MEALY = 0` (Moore form) the request depends on the state alone. With `MEALY = 1` (Mealy form) the request depends on the state and the inputs together. The state register and the transitions are the same in both forms.

Top module: `wake_alarm_fsm`

## Requirements
- R1: While `rst_n` is 0 at a rising clock edge, the state becomes asleep (`state_o` = 2'b00). `off_req_o` reads 0 for as long as `rst_n` is held at 0, whatever the value of `alarm_i`.
- R2: In the asleep state (2'b00) with `alarm_i` = 0, the next state is asleep, for either value of `weekday_i`.
- R3: In the asleep state with `alarm_i` = 1, the next state is awake in bed (2'b01).
- R4: In the awake-in-bed state with `alarm_i` = 1, the next state is awake in bed, for either value of `weekday_i`.
- R5: In the awake-in-bed state with `alarm_i` = 0 and `weekday_i` = 1, the next state is up (2'b10).
- R6: In the awake-in-bed state with `alarm_i` = 0 and `weekday_i` = 0, the next state is asleep.
- R7: The up state (2'b10) is left only through reset, whatever the inputs are, and `off_req_o` is 0 while the machine is in it.
- R8: With `MEALY` = 0, outside reset, `off_req_o` is 1 exactly when the state is awake in bed, whatever the inputs are.
- R9: With `MEALY` = 1, outside reset, `off_req_o` is 1 exactly when `alarm_i` = 1 and the state is asleep or awake in bed. It is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_i | input | 1 | 1 while the alarm is sounding |
| weekday_i | input | 1 | 1 on a working day |
| off_req_o | output | 1 | Request to switch the alarm off |
| state_o | output | 2 | Current state: 00 asleep, 01 awake in bed, 10 up |

## Verification
On every cycle, the assertions check each transition arc, that the up state is absorbing and silent, and that reset forces the asleep state with the request low. They also check how the request relates to the previous or next state: a Moore request implies the alarm rang in the previous cycle, and a Mealy request implies the next state is awake in bed. Some behaviour can only be shown by the bench's scenarios. These are that the two output forms differ in the same cycle for the same stimulus, that the machine returns to sleep and wakes again, and that a reset releases the up state. To show these, the bench runs one instance of each form in lockstep against a reference model.

// File: rtl/wake_pkg.sv
// Package wake_pkg
// Shared state codes for the wake-up alarm controller.
// Assumes a two-bit state register; code 2'b11 is never produced by a
// legal transition and is treated as asleep by the next-state logic.
package wake_pkg;
    localparam int ST_W = 2;
    typedef logic [ST_W-1:0] wake_code_t;

    localparam wake_code_t CODE_ASLEEP = 2'b00;
    localparam wake_code_t CODE_IN_BED = 2'b01;
    localparam wake_code_t CODE_UP     = 2'b10;
endpackage

// File: rtl/wake_next.sv
// Module wake_next
// Combinational transition function of the wake-up controller.
// Assumes the arcs out of every state are mutually exclusive and cover
// all four input combinations; an illegal code falls back to asleep.
module wake_next
    import wake_pkg::*;
(
    input  wake_code_t cur_i,
    input  logic       alarm_i,
    input  logic       weekday_i,
    output wake_code_t nxt_o
);
    // Pick the successor state from the present state and the inputs.
    always_comb begin
        case (cur_i)
            CODE_ASLEEP: nxt_o = alarm_i ? CODE_IN_BED : CODE_ASLEEP;
            CODE_IN_BED: begin
                if (alarm_i)        nxt_o = CODE_IN_BED;
                else if (weekday_i) nxt_o = CODE_UP;
                else                nxt_o = CODE_ASLEEP;
            end
            CODE_UP:     nxt_o = CODE_UP;
            default:     nxt_o = CODE_ASLEEP;
        endcase
    end
endmodule

// File: rtl/wake_state_reg.sv
// Module wake_state_reg
// State register with synchronous active-low reset to asleep.
// Assumes rst_n is synchronous to clk.
module wake_state_reg
    import wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wake_code_t nxt_i,
    output wake_code_t cur_o
);
    // Capture the next state, or asleep while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_o <= CODE_ASLEEP;
        else        cur_o <= nxt_i;
    end
endmodule

// File: rtl/wake_out.sv
// Module wake_out
// Output decoder for the switch-off request. MEALY selects the form:
// 0 decodes the state alone, 1 decodes state and alarm together.
// Assumes the request must stay low while reset is held.
module wake_out
    import wake_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  logic       rst_n,
    input  wake_code_t cur_i,
    input  logic       alarm_i,
    output logic       off_o
);
    logic raw_off;

    generate
        if (MEALY) begin : g_mealy
            // Request on the arcs taken while the alarm sounds.
            always_comb begin
                raw_off = alarm_i &&
                          ((cur_i == CODE_ASLEEP) || (cur_i == CODE_IN_BED));
            end
        end else begin : g_moore
            logic alarm_unused;
            // Request tied to the awake-in-bed state only.
            always_comb begin
                raw_off      = (cur_i == CODE_IN_BED);
                alarm_unused = alarm_i;
            end
        end
    endgenerate

    // Hold the request low during reset.
    always_comb off_o = rst_n && raw_off;
endmodule

// File: rtl/wake_alarm_fsm.sv
// Module wake_alarm_fsm
// Top of the wake-up alarm controller: next-state logic, state register
// and output decoder, with the state code brought out for observation.
// Assumes synchronous inputs; alarm source and debouncing are external.
module wake_alarm_fsm
    import wake_pkg::*;
#(
    parameter bit MEALY = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alarm_i,
    input  logic            weekday_i,
    output logic            off_req_o,
    output logic [ST_W-1:0] state_o
);
    wake_code_t cur_q;
    wake_code_t nxt_d;

    wake_next u_next (
        .cur_i     (cur_q),
        .alarm_i   (alarm_i),
        .weekday_i (weekday_i),
        .nxt_o     (nxt_d)
    );

    wake_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt_i (nxt_d),
        .cur_o (cur_q)
    );

    wake_out #(.MEALY(MEALY)) u_out (
        .rst_n   (rst_n),
        .cur_i   (cur_q),
        .alarm_i (alarm_i),
        .off_o   (off_req_o)
    );

    // Expose the state code.
    always_comb state_o = cur_q;

    // Reset behaviour (R1)
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> state_o == CODE_ASLEEP);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !off_req_o);

    // Transition arcs (R2..R7)
    p_asleep_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CODE_ASLEEP && !alarm_i) |=> state_o == CODE_ASLEEP);
    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CODE_ASLEEP && alarm_i) |=> state_o == CODE_IN_BED);
    p_bed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CODE_IN_BED && alarm_i) |=> state_o == CODE_IN_BED);
    p_get_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CODE_IN_BED && !alarm_i && weekday_i) |=> state_o == CODE_UP);
    p_back_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CODE_IN_BED && !alarm_i && !weekday_i) |=> state_o == CODE_ASLEEP);
    p_up_absorb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == CODE_UP |=> state_o == CODE_UP);
    p_up_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == CODE_UP |-> !off_req_o);

    generate
        if (MEALY) begin : g_chk_mealy
            // A Mealy request always leads into awake in bed (R9)
            p_req_leads_bed_r9: assert property (@(posedge clk) disable iff (!rst_n)
                off_req_o |=> state_o == CODE_IN_BED);
            p_ring_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (state_o == CODE_ASLEEP && alarm_i) |-> off_req_o);
        end else begin : g_chk_moore
            // A Moore request needs the alarm in the previous cycle (R8)
            p_req_after_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
                off_req_o |-> $past(alarm_i));
            p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(state_o) && state_o == CODE_IN_BED |-> off_req_o);
        end
    endgenerate
endmodule

// File: tb/wake_alarm_fsm_test.sv
`timescale 1ns/1ps
// Bench: drives a Moore and a Mealy instance in lockstep. A driver task
// computes expected results from a reference model and queues them; a
// monitor pops each item and compares it with the design outputs.
module wake_alarm_fsm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm = 1'b0;
    logic       weekday = 1'b0;
    logic       off_moore, off_mealy;
    logic [1:0] st_moore, st_mealy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] st;
        logic       mo;
        logic       me;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic [1:0] model_st;

    always #2.5 clk = ~clk;

    wake_alarm_fsm #(.MEALY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .weekday_i(weekday),
        .off_req_o(off_moore), .state_o(st_moore)
    );
    wake_alarm_fsm #(.MEALY(1'b1)) uut_mly (
        .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .weekday_i(weekday),
        .off_req_o(off_mealy), .state_o(st_mealy)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input bit rst, input bit a, input bit w, input string tag);
        exp_t e;
        logic [1:0] nx;
        @(negedge clk);
        rst_n   = ~rst;
        alarm   = a;
        weekday = w;
        e.st  = model_st;
        e.mo  = !rst && (model_st == 2'b01);
        e.me  = !rst && a && (model_st == 2'b00 || model_st == 2'b01);
        e.tag = tag;
        exp_q.push_back(e);
        case (model_st)
            2'b00:   nx = a ? 2'b01 : 2'b00;
            2'b01:   nx = a ? 2'b01 : (w ? 2'b10 : 2'b00);
            2'b10:   nx = 2'b10;
            default: nx = 2'b00;
        endcase
        model_st = rst ? 2'b00 : nx;
    endtask

    // Monitor: compare each queued item once inputs have settled.
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " state moore"}, st_moore, e.st);
            check({e.tag, " state mealy"}, st_mealy, e.st);
            check({e.tag, " R8 moore out"}, {1'b0, off_moore}, {1'b0, e.mo});
            check({e.tag, " R9 mealy out"}, {1'b0, off_mealy}, {1'b0, e.me});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with the alarm ringing
        alarm = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset state moore", st_moore, 2'b00);
        check("R1 reset state mealy", st_mealy, 2'b00);
        check("R1 reset moore out", {1'b0, off_moore}, 2'b00);
        check("R1 reset mealy out", {1'b0, off_mealy}, 2'b00);
        model_st = 2'b00;

        step(0, 0, 0, "R2 asleep quiet wkend");
        step(0, 0, 1, "R2 asleep quiet wkday");
        step(0, 1, 0, "R3 asleep ring");
        step(0, 1, 1, "R4 bed ring wkday");
        step(0, 1, 0, "R4 bed ring wkend");
        step(0, 0, 0, "R6 bed quiet wkend");
        step(0, 1, 1, "R3 asleep ring again");
        step(0, 0, 1, "R5 bed quiet wkday");
        step(0, 1, 0, "R7 up ring");
        step(0, 1, 1, "R7 up ring wkday");
        step(0, 0, 0, "R7 up quiet");
        step(1, 1, 1, "R1 reset from up");
        step(0, 0, 0, "R2 after reset");
        step(0, 1, 1, "R3 wake after reset");
        step(0, 0, 1, "R5 get up after reset");
        step(0, 0, 0, "R7 up holds");

        @(negedge clk);
        @(negedge clk);
        #2;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule